// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block derives the two timing clocks of a stereo serial audio link from a master-clock tick stream. A one-cycle pulse on `mclk_tick` marks each master-clock period. The bit clock `sclk` runs at the master rate divided by 2 or 4. The frame clock `lrclk` is a 50% duty square wave whose half period is 16, 32 or 64 bit-clock periods. For each of these clocks the block also produces single-cycle edge pulses, so logic in the same clock domain can shift audio data without detecting edges itself.

A 32-bit control word sets the block up. It holds a run enable, a bit-clock ratio, a frame ratio, a polarity bit and an override flag. When the override flag is clear, the audio port supplies its own ratios on separate pins, and the block uses those instead of the ratio fields in the control word. The block latches the selected configuration, so a ratio change never cuts a frame short.

Top module: `aclk_serial_gen`

## Requirements
- R1: While control bit 31 (enable) is 0, `sclk`, `lrclk`, `sclk_rise`, `sclk_fall`, `lr_tog` and `cfg_err` are all 0 from the next clock cycle onward.
- R2: Latched divider bit 0 makes `sclk` toggle on every `mclk_tick` (master/2). Latched divider bit 1 makes it toggle on every second tick (master/4). `sclk` changes only in the cycle after a tick.
- R3: Latched frame code 0, 1 or 2 toggles `lrclk` after 16, 32 or 64 active `sclk` edges, which gives a 50% duty frame clock of 32, 64 or 128 bit periods.
- R4: Frame code 3 is reserved. While it is latched and the block is enabled, `cfg_err` is 1 and `lrclk` holds its level. The configuration reloads at every active `sclk` edge, so after leaving code 3 the next `lrclk` toggle comes after 1 plus the new half count of active edges.
- R5: Control bit 19 (polarity) set to 1 makes `lrclk` change only in the cycle where `sclk` falls. Set to 0, it makes `lrclk` change only where `sclk` rises. The active edge counted by R3 is the one that polarity selects.
- R6: When control bit 29 (override) is 1, the divider comes from control bit 16 and the frame code from bits 18:17. When bit 29 is 0, they come from `port_div4` and `port_lr_code`. Polarity always comes from bit 19, and all other control bits are ignored.
- R7: The first cycle that samples the enable as 1 loads the configuration. Counting starts in the following cycle from zero, with `sclk` low, so the first `lrclk` rise follows a complete half frame.
- R8: The divider, frame code and polarity are latched. A new value takes effect only at an `lrclk` falling transition (frame boundary), while the block is disabled, or under R4.
- R9: `sclk_rise` and `sclk_fall` are one-cycle pulses, high in the cycle where `sclk` first shows its new level. `lr_tog` is high in the cycle where `lrclk` first shows its new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_tick | input | 1 | One pulse per master-clock period |
| ctrl_word | input | 32 | Control word: enable 31, override 29, polarity 19, frame code 18:17, divider 16 |
| port_div4 | input | 1 | Divider select supplied by the audio port |
| port_lr_code | input | 2 | Frame code supplied by the audio port |
| sclk | output | 1 | Bit clock |
| lrclk | output | 1 | Frame clock |
| sclk_rise | output | 1 | Pulse: bit clock has just risen |
| sclk_fall | output | 1 | Pulse: bit clock has just fallen |
| lr_tog | output | 1 | Pulse: frame clock has just changed |
| cfg_err | output | 1 | Reserved frame code latched while enabled |

## Verification
The assertions assume that `mclk_tick` and the control inputs are synchronous to `clk` and change only between edges. They also assume that a disable may arrive in any cycle, which is why edge and pulse relations are conditioned on the enable seen in the previous cycle. The stimulus drives every input a fixed delay after the falling clock edge. It draws the tick density, the control fields, the port-supplied ratios and the unused control bits at random, and it toggles the enable at arbitrary points inside a frame.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

  localparam int unsigned CTRL_W   = 32;
  localparam int unsigned EN_BIT   = 31;
  localparam int unsigned OVR_BIT  = 29;
  localparam int unsigned POL_BIT  = 19;
  localparam int unsigned LR_LSB   = 17;
  localparam int unsigned DIV_BIT  = 16;
  localparam logic [1:0]  LR_RSVD  = 2'd3;

  typedef struct packed {
    logic       div4;
    logic [1:0] lr_code;
    logic       fall_align;
  } aclk_cfg_t;

endpackage

// File: rtl/aclk_cfg_reg.sv
module aclk_cfg_reg
  import aclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              port_div4,
  input  logic [1:0]        port_lr_code,
  output aclk_cfg_t         cfg_q
);

  aclk_cfg_t cfg_d;

  always_comb begin
    cfg_d.fall_align = ctrl[POL_BIT];
    if (ctrl[OVR_BIT]) begin
      cfg_d.div4    = ctrl[DIV_BIT];
      cfg_d.lr_code = ctrl[LR_LSB +: 2];
    end else begin
      cfg_d.div4    = port_div4;
      cfg_d.lr_code = port_lr_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (load) cfg_q <= cfg_d;
  end

endmodule

// File: rtl/aclk_bit_div.sv
module aclk_bit_div #(
  parameter int unsigned HALF_A = 1,
  parameter int unsigned HALF_B = 2,
  localparam int unsigned HMAX  = (HALF_A > HALF_B) ? HALF_A : HALF_B,
  localparam int unsigned CW    = (HMAX > 1) ? $clog2(HMAX) : 1
)(
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick,
  input  logic use_b,
  output logic sclk,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic rise_now,
  output logic fall_now
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          wrap;

  assign last     = use_b ? CW'(HALF_B - 1) : CW'(HALF_A - 1);
  assign wrap     = active && tick && (cnt == last);
  assign rise_now = wrap && !sclk;
  assign fall_now = wrap && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      sclk      <= 1'b0;
      sclk_rise <= 1'b0;
      sclk_fall <= 1'b0;
    end else if (!active) begin
      cnt       <= '0;
      sclk      <= 1'b0;
      sclk_rise <= 1'b0;
      sclk_fall <= 1'b0;
    end else begin
      sclk_rise <= rise_now;
      sclk_fall <= fall_now;
      if (tick) cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap) sclk <= !sclk;
    end
  end

endmodule

// File: rtl/aclk_frame_div.sv
module aclk_frame_div
  import aclk_pkg::*;
#(
  parameter int unsigned HALF_MIN = 16,
  localparam int unsigned CW      = $clog2(HALF_MIN * 4)
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       step,
  input  logic [1:0] code,
  output logic       lrclk,
  output logic       lr_tog,
  output logic       boundary,
  output logic       hold_step
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          reserved;
  logic          wrap;

  assign reserved  = (code == LR_RSVD);
  assign last      = CW'((HALF_MIN << code) - 1);
  assign wrap      = active && step && !reserved && (cnt == last);
  assign boundary  = wrap && lrclk;
  assign hold_step = active && step && reserved;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      lrclk  <= 1'b0;
      lr_tog <= 1'b0;
    end else if (!active) begin
      cnt    <= '0;
      lrclk  <= 1'b0;
      lr_tog <= 1'b0;
    end else begin
      lr_tog <= wrap;
      if (step && !reserved) cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap) lrclk <= !lrclk;
    end
  end

endmodule

// File: rtl/aclk_serial_gen.sv
module aclk_serial_gen
  import aclk_pkg::*;
#(
  parameter int unsigned MCLK_HALF_FAST = 1,
  parameter int unsigned MCLK_HALF_SLOW = 2,
  parameter int unsigned LR_HALF_MIN    = 16
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mclk_tick,
  input  logic [31:0] ctrl_word,
  input  logic        port_div4,
  input  logic [1:0]  port_lr_code,
  output logic        sclk,
  output logic        lrclk,
  output logic        sclk_rise,
  output logic        sclk_fall,
  output logic        lr_tog,
  output logic        cfg_err
);

  aclk_cfg_t cfg;
  logic      run;
  logic      active;
  logic      rise_now;
  logic      fall_now;
  logic      step;
  logic      boundary;
  logic      hold_step;
  logic      load;

  assign active  = ctrl_word[EN_BIT] && run;
  assign step    = cfg.fall_align ? fall_now : rise_now;
  assign load    = !run || boundary || hold_step;
  assign cfg_err = active && (cfg.lr_code == LR_RSVD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= 1'b0;
    else        run <= ctrl_word[EN_BIT];
  end

  aclk_cfg_reg u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (load),
    .ctrl         (ctrl_word),
    .port_div4    (port_div4),
    .port_lr_code (port_lr_code),
    .cfg_q        (cfg)
  );

  aclk_bit_div #(
    .HALF_A (MCLK_HALF_FAST),
    .HALF_B (MCLK_HALF_SLOW)
  ) u_bit (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .tick      (mclk_tick),
    .use_b     (cfg.div4),
    .sclk      (sclk),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .rise_now  (rise_now),
    .fall_now  (fall_now)
  );

  aclk_frame_div #(
    .HALF_MIN (LR_HALF_MIN)
  ) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .step      (step),
    .code      (cfg.lr_code),
    .lrclk     (lrclk),
    .lr_tog    (lr_tog),
    .boundary  (boundary),
    .hold_step (hold_step)
  );

endmodule

// File: rtl/aclk_serial_gen_chk.sv
module aclk_serial_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic mclk_tick,
  input logic sclk,
  input logic lrclk,
  input logic sclk_rise,
  input logic sclk_fall,
  input logic lr_tog,
  input logic cfg_err
);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sclk && !lrclk && !sclk_rise && !sclk_fall && !lr_tog))
    else $error("p_idle_r1");

  p_sclk_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((sclk != $past(sclk)) && $past(en)) |-> $past(mclk_tick))
    else $error("p_sclk_on_tick_r2");

  p_rsvd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && $past(cfg_err)) |-> $stable(lrclk))
    else $error("p_rsvd_hold_r4");

  p_lr_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lr_tog |-> ((sclk_rise || sclk_fall) && $onehot0({sclk_rise, sclk_fall})))
    else $error("p_lr_on_edge_r5");

  p_rise_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |-> $rose(sclk))
    else $error("p_rise_pulse_r9");

  p_fall_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_fall |-> $fell(sclk))
    else $error("p_fall_pulse_r9");

  p_lr_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lr_tog |-> (lrclk != $past(lrclk)))
    else $error("p_lr_pulse_r9");

endmodule

bind aclk_serial_gen aclk_serial_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (ctrl_word[31]),
  .mclk_tick (mclk_tick),
  .sclk      (sclk),
  .lrclk     (lrclk),
  .sclk_rise (sclk_rise),
  .sclk_fall (sclk_fall),
  .lr_tog    (lr_tog),
  .cfg_err   (cfg_err)
);

// File: tb/aclk_serial_gen_tb.sv
`timescale 1ns/1ps
module aclk_serial_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mclk_tick = 1'b0;
  logic        port_div4 = 1'b0;
  logic [1:0]  port_lr_code = 2'd0;
  logic        b_en = 0, b_ovr = 0, b_div4 = 0, b_pol = 0;
  logic [1:0]  b_code = 0;
  logic [15:0] b_junk = 0;
  logic [8:0]  b_junk2 = 0;
  logic [31:0] ctrl_word;
  logic        sclk, lrclk, sclk_rise, sclk_fall, lr_tog, cfg_err;

  int checks = 0, errors = 0;
  int tick_prob = 100;
  bit done = 0;

  assign ctrl_word = {b_en, 1'b0, b_ovr, b_junk2, b_pol, b_code, b_div4, b_junk};

  always #10 clk = ~clk;

  aclk_serial_gen u_dut (
    .clk(clk), .rst_n(rst_n), .mclk_tick(mclk_tick), .ctrl_word(ctrl_word),
    .port_div4(port_div4), .port_lr_code(port_lr_code),
    .sclk(sclk), .lrclk(lrclk), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .lr_tog(lr_tog), .cfg_err(cfg_err)
  );

  // Behavioural expectation built from the requirements
  bit m_run, m_sclk, m_lr, m_rise, m_fall, m_tog, m_div4, m_pol;
  int m_mc, m_bc, m_code;

  always @(posedge clk) begin
    bit act, st, bnd, hold, nd, np;
    int nc;
    if (!rst_n) begin
      m_run = 0; m_sclk = 0; m_lr = 0; m_rise = 0; m_fall = 0; m_tog = 0;
      m_div4 = 0; m_pol = 0; m_mc = 0; m_bc = 0; m_code = 0;
    end else begin
      act = b_en && m_run;
      nd  = b_ovr ? b_div4 : port_div4;
      nc  = b_ovr ? int'(b_code) : int'(port_lr_code);
      np  = b_pol;
      bnd = 0; hold = 0;
      if (!act) begin
        m_mc = 0; m_sclk = 0; m_bc = 0; m_lr = 0;
        m_rise = 0; m_fall = 0; m_tog = 0;
      end else begin
        m_rise = 0; m_fall = 0; m_tog = 0;
        if (mclk_tick) begin
          if (m_mc == (m_div4 ? 2 : 1) - 1) begin
            m_mc = 0;
            m_sclk = !m_sclk;
            m_rise = m_sclk;
            m_fall = !m_sclk;
          end else m_mc++;
        end
        st = m_pol ? m_fall : m_rise;
        if (st) begin
          if (m_code == 3) hold = 1;
          else if (m_bc == (16 << m_code) - 1) begin
            m_bc = 0; bnd = m_lr; m_lr = !m_lr; m_tog = 1;
          end else m_bc++;
        end
      end
      if (!m_run || bnd || hold) begin
        m_div4 = nd; m_code = nc; m_pol = np;
      end
      m_run = b_en;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle compare against the model, then the random tick
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(sclk == m_sclk, "R2 sclk level", sclk, m_sclk);
      chk(lrclk == m_lr, "R3 lrclk level", lrclk, m_lr);
      chk({sclk_rise, sclk_fall, lr_tog} == {m_rise, m_fall, m_tog},
          "R9 edge pulses", {sclk_rise, sclk_fall, lr_tog}, {m_rise, m_fall, m_tog});
      chk(cfg_err == (b_en && m_run && m_code == 3), "R4 cfg_err",
          cfg_err, (b_en && m_run && m_code == 3));
    end
    #1 mclk_tick = ($urandom % 100) < tick_prob;
  end

  function automatic bit act_pulse(input bit pol);
    return pol ? sclk_fall : sclk_rise;
  endfunction

  task automatic step_in();
    @(negedge clk); #2;
  endtask

  task automatic cfg(input bit en, input bit ovr, input bit d4, input int code, input bit pol);
    step_in();
    b_en = en; b_ovr = ovr; b_div4 = d4; b_code = code[1:0]; b_pol = pol;
    b_junk = 16'($urandom); b_junk2 = 9'($urandom);
  endtask

  // Active edges up to and including the next lr_tog
  task automatic count_next(input bit pol, output int n);
    int lim = 0;
    n = 0;
    do begin
      @(negedge clk); lim++;
      if (act_pulse(pol)) n++;
    end while (!lr_tog && lim < 8000);
    if (lim >= 8000) n = -1;
  endtask

  task automatic wait_tog(input bit want_level);
    int lim = 0;
    do begin @(negedge clk); lim++; end
    while (!(lr_tog && lrclk == want_level) && lim < 8000);
  endtask

  task automatic restart(input bit ovr, input bit d4, input int code, input bit pol);
    cfg(0, ovr, d4, code, pol);
    repeat (3) step_in();
    cfg(1, ovr, d4, code, pol);
  endtask

  initial begin
    int n, per, lim;
    bit lr0;
    void'($urandom(32'h5eed_a1c3));
    repeat (4) @(negedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk(!sclk && !lrclk && !cfg_err, "R1 reset idle", {sclk, lrclk, cfg_err}, 0);

    // R7 / R3: first half after enable is complete, all codes
    for (int c = 0; c < 3; c++) begin
      tick_prob = 70;
      restart(1, c[0], c, 0);
      count_next(0, n);
      chk(n == (16 << c), "R7 first half frame", n, 16 << c);
      count_next(0, n);
      chk(n == (16 << c), "R3 half frame length", n, 16 << c);
    end

    // R2: bit clock period in cycles with a tick every cycle
    for (int d = 0; d < 2; d++) begin
      tick_prob = 100;
      restart(1, d[0], 0, 0);
      lim = 0;
      do begin @(negedge clk); lim++; end while (!sclk_rise && lim < 100);
      per = 0;
      do begin @(negedge clk); per++; end while (!sclk_rise && per < 100);
      chk(per == (d ? 4 : 2), "R2 sclk period", per, d ? 4 : 2);
    end

    // R5: falling-edge alignment
    tick_prob = 60;
    restart(1, 0, 0, 1);
    count_next(1, n);
    chk(sclk_fall && !sclk, "R5 lrclk on falling sclk", sclk_fall, 1);
    chk(n == 16, "R5 falling edges counted", n, 16);
    restart(1, 1, 0, 0);
    count_next(0, n);
    chk(sclk_rise && sclk, "R5 lrclk on rising sclk", sclk_rise, 1);

    // R6: port-supplied ratios when override is clear
    port_div4 = 0; port_lr_code = 2'd1;
    restart(0, 1, 0, 0);
    count_next(0, n);
    chk(n == 32, "R6 port frame code used", n, 32);
    port_lr_code = 2'd2;
    cfg(1, 1, 1, 0, 0);
    wait_tog(0);
    count_next(0, n);
    chk(n == 16, "R6 override frame code used", n, 16);

    // R8: ratio change mid-frame waits for boundary
    restart(1, 0, 0, 0);
    wait_tog(1);
    cfg(1, 1, 0, 2, 0);
    count_next(0, n);
    chk(n == 16, "R8 old ratio until boundary", n, 16);
    count_next(0, n);
    chk(n == 64, "R8 new ratio after boundary", n, 64);

    // R4: reserved code
    restart(1, 0, 0, 0);
    step_in();
    cfg(1, 1, 0, 3, 0);
    lim = 0;
    do begin @(negedge clk); lim++; end while (!cfg_err && lim < 4000);
    chk(cfg_err, "R4 error raised", cfg_err, 1);
    chk(!lrclk, "R4 entered at boundary", lrclk, 0);
    lr0 = lrclk;
    n = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (lrclk != lr0 || lr_tog || !cfg_err) n++;
    end
    chk(n == 0, "R4 lrclk held", n, 0);
    cfg(1, 1, 0, 0, 0);
    count_next(0, n);
    chk(n == 17, "R4 exit after one edge plus half", n, 17);

    // R1: disable mid-frame
    cfg(0, 1, 0, 0, 0);
    @(negedge clk);
    n = 0;
    for (int k = 0; k < 50; k++) begin
      if (sclk || lrclk || sclk_rise || sclk_fall || lr_tog || cfg_err) n++;
      @(negedge clk);
    end
    chk(n == 0, "R1 disabled idle", n, 0);

    // Random mix, checked cycle by cycle against the model
    for (int it = 0; it < 10; it++) begin
      tick_prob = 20 + ($urandom % 81);
      port_div4 = 1'($urandom); port_lr_code = 2'($urandom);
      cfg(1, 1'($urandom), 1'($urandom), $urandom % 4, 1'($urandom));
      for (int k = 0; k < 400 + ($urandom % 800); k++) begin
        step_in();
        if (($urandom % 200) == 0) begin
          b_ovr = 1'($urandom); b_div4 = 1'($urandom);
          b_code = 2'($urandom); b_pol = 1'($urandom);
          port_div4 = 1'($urandom); port_lr_code = 2'($urandom);
        end
        if (($urandom % 500) == 0) b_en = !b_en;
        b_junk = 16'($urandom);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule